// File: doc/BRIEF.md
# Daisy-Chain Attenuator Frame Transmitter

This block is the master side of a three-wire control link that programs a chain of N serially connected attenuator devices. Software or a sequencer hands it one 16-bit word per device over a valid/ready input. The upper byte of each word selects a channel and the lower byte selects the attenuation code. Once all N words are held, the block drives one unbroken burst of 16·N clocked bits while the shift enable stays low. It then raises the enable, and every device in the chain latches its new word on that same rising edge.

The word that enters first is meant for the device farthest from the master, and it leaves first. The bits of each word go out most significant bit first. Data changes while the serial clock is low, so it is steady at every rising edge. The lead time before the first rising edge, the clock half period and the recovery time after the burst are parameters counted in system clock cycles. Their defaults are 8, 13 and 10 cycles. At 50 MHz this gives 160 ns of lead time and a serial clock of about 1.92 MHz.

The controller has five states:
- ST_IDLE: collects words.
- ST_LEAD: enable low, clock low, waiting out the lead time.
- ST_HIGH: clock high.
- ST_LOW: clock low.
- ST_RECOVER: enable high, waiting out the recovery time.

It has these transitions:
- ST_IDLE→ST_LEAD when the N-th word is accepted.
- ST_LEAD→ST_HIGH when the lead time has elapsed.
- ST_HIGH→ST_LOW when the half period has elapsed.
- ST_LOW→ST_HIGH when the half period has elapsed and bits remain.
- ST_LOW→ST_RECOVER when the half period has elapsed and all bits have been clocked.
- ST_RECOVER→ST_IDLE when the recovery time has elapsed.

Top module: `chain_frame_tx`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The N-th word taken starts a burst. `in_valid` asserted while busy has no effect on any later burst.
- R2: `shift_en_n` falls in the cycle after the N-th word is accepted. It then stays low with `sclk` low for exactly LEAD_CYC cycles before the first rising edge of `sclk`.
- R3: Within one enable-low window, `sclk` produces exactly 16·N high pulses, and `sclk` is never high while `shift_en_n` is high.
- R4: Each high phase and each low phase of `sclk` lasts HALF_DIV cycles, and `sclk` idles low.
- R5: Words leave in the order they were accepted, each MSB first. Word bits 15:8 (channel byte) therefore precede bits 7:0 (attenuation byte), and overall bit k carries bit 15−(k mod 16) of word ⌊k/16⌋.
- R6: `sdata` takes the first bit when the enable falls and changes only when `sclk` falls. After the last high phase, the block holds one more low half period and then raises `shift_en_n`. `sdata` is 0 whenever no bit is being presented.
- R7: `busy` is high from the cycle after the N-th acceptance until HOLD_CYC cycles after `shift_en_n` has risen.
- R8: An active-low asynchronous reset gives `sclk`=0, `shift_en_n`=1, `sdata`=0, `busy`=0 and `in_ready`=1. It discards any partly collected words and any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes a word this cycle if one is offered |
| in_word | input | 16 | Channel byte in 15:8, attenuation code in 7:0 |
| sclk | output | 1 | Serial clock to the chain, idles low |
| shift_en_n | output | 1 | Active-low shift enable; its rising edge latches the chain |
| sdata | output | 1 | Serial data to the first device |
| busy | output | 1 | A burst or its recovery time is in progress |

## Verification
The bench builds the block for a chain of two devices, with a half period of 2 cycles, a lead time of 3 cycles and a recovery time of 4 cycles. Each burst is therefore only 131 cycles long, which lets the bench run several complete bursts in a short run:
- words with all bits set, all bits clear and alternating bits;
- offers held back by gaps;
- offers made while the block is busy;
- resets arriving both during collection and in the middle of a burst.

Word-order errors and address-versus-code byte swaps show up with two devices that they cannot show with one. The small timing parameters still leave every phase longer than one cycle, so counting errors of one cycle in any phase are visible.

// File: rtl/chain_tx_pkg.sv
package chain_tx_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_RECOVER
    } tx_state_e;
endpackage

// File: rtl/chain_word_store.sv
module chain_word_store #(
    parameter int N_WORDS = 3,
    parameter int WORD_W  = 16,
    parameter int IW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              last_slot
);
    logic [IW-1:0]     fill_q;
    logic [WORD_W-1:0] slot_q [N_WORDS];

    assign last_slot = (fill_q == IW'(N_WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (push) begin
            fill_q <= last_slot ? '0 : fill_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (push && (fill_q == IW'(g))) begin
                slot_q[g] <= push_word;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_word = slot_q[i];
            end
        end
    end

    // R1: the fill pointer never passes the last slot
    a_r1_fill_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= IW'(N_WORDS - 1));
endmodule

// File: rtl/chain_phase_timer.sv
module chain_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = (CW'(cnt_q + 1'b1) == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
    import chain_tx_pkg::*;
#(
    parameter int N_DEV    = 3,
    parameter int HALF_DIV = 13,
    parameter int LEAD_CYC = 8,
    parameter int HOLD_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              sclk,
    output logic              shift_en_n,
    output logic              sdata,
    output logic              busy
);
    localparam int TOTAL_BITS = WORD_W * N_DEV;
    localparam int BW   = $clog2(TOTAL_BITS + 1);
    localparam int IW   = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int SW   = $clog2(WORD_W);
    localparam int MAX1 = (HALF_DIV > LEAD_CYC) ? HALF_DIV : LEAD_CYC;
    localparam int MAXC = (MAX1 > HOLD_CYC) ? MAX1 : HOLD_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    tx_state_e         state_q, state_d;
    logic              accept, last_slot, phase_done, phase_clear, drive_bit;
    logic [CW-1:0]     phase_limit;
    logic [BW-1:0]     bit_q;
    logic [IW-1:0]     word_idx;
    logic [SW-1:0]     bit_pos;
    logic [WORD_W-1:0] cur_word;

    assign accept = in_valid && in_ready;

    chain_word_store #(
        .N_WORDS (N_DEV),
        .WORD_W  (WORD_W),
        .IW      (IW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_word (in_word),
        .rd_idx    (word_idx),
        .rd_word   (cur_word),
        .last_slot (last_slot)
    );

    chain_phase_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_clear),
        .limit (phase_limit),
        .done  (phase_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept && last_slot) state_d = ST_LEAD;
            ST_LEAD:    if (phase_done) state_d = ST_HIGH;
            ST_HIGH:    if (phase_done) state_d = ST_LOW;
            ST_LOW:     if (phase_done)
                            state_d = (bit_q == BW'(TOTAL_BITS)) ? ST_RECOVER : ST_HIGH;
            ST_RECOVER: if (phase_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit position in the burst; advances as the clock falls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (state_q == ST_IDLE) begin
            bit_q <= '0;
        end else if (state_q == ST_HIGH && phase_done) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // Phase length for the current state
    always_comb begin
        unique case (state_q)
            ST_LEAD:         phase_limit = CW'(LEAD_CYC);
            ST_HIGH, ST_LOW: phase_limit = CW'(HALF_DIV);
            ST_RECOVER:      phase_limit = CW'(HOLD_CYC);
            default:         phase_limit = CW'(1);
        endcase
    end

    assign phase_clear = (state_d != state_q) || (state_q == ST_IDLE);

    assign word_idx = IW'(bit_q / BW'(WORD_W));
    assign bit_pos  = SW'(WORD_W - 1) - SW'(bit_q % BW'(WORD_W));

    // Outputs
    always_comb begin
        sclk       = 1'b0;
        shift_en_n = 1'b1;
        busy       = 1'b1;
        in_ready   = 1'b0;
        drive_bit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                in_ready = 1'b1;
            end
            ST_LEAD: begin
                shift_en_n = 1'b0;
                drive_bit  = 1'b1;
            end
            ST_HIGH: begin
                shift_en_n = 1'b0;
                sclk       = 1'b1;
                drive_bit  = 1'b1;
            end
            ST_LOW: begin
                shift_en_n = 1'b0;
                drive_bit  = (bit_q != BW'(TOTAL_BITS));
            end
            ST_RECOVER: begin
                drive_bit = 1'b0;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
        sdata = drive_bit & cur_word[bit_pos];
    end

    // Checker: length of each high phase of the serial clock
    logic [CW-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else begin
            hi_run_q <= sclk ? hi_run_q + 1'b1 : '0;
        end
    end

    a_r3_clock_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !shift_en_n);

    a_r4_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run_q == CW'(HALF_DIV)));

    a_r6_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    a_r6_release_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_en_n) |-> (!sclk && busy));

    a_r2_enable_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_en_n) |-> !sclk);

    a_r7_no_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
endmodule

// File: tb/chain_frame_tx_bench.sv
module chain_frame_tx_bench;
    localparam int N  = 2;
    localparam int H  = 2;
    localparam int L  = 3;
    localparam int D  = 4;
    localparam int TOT   = 16 * N;
    localparam int BURST = L + 2 * H * TOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0000;
    logic        in_ready, sclk, shift_en_n, sdata, busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    chain_frame_tx #(
        .N_DEV    (N),
        .HALF_DIV (H),
        .LEAD_CYC (L),
        .HOLD_CYC (D)
    ) u_chain_frame_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .sclk       (sclk),
        .shift_en_n (shift_en_n),
        .sdata      (sdata),
        .busy       (busy)
    );

    // Behavioural reference: 0 idle, 1 burst, 2 recovery
    int          m_mode = 0;
    int          m_t    = 0;
    logic [15:0] m_q[$];
    logic [15:0] m_frame[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            m_t    = 0;
            m_q.delete();
        end else begin
            case (m_mode)
                0: if (in_valid) begin
                       m_q.push_back(in_word);
                       if (m_q.size() == N) begin
                           m_frame = m_q;
                           m_q.delete();
                           m_mode = 1;
                           m_t    = 0;
                       end
                   end
                1: begin
                       m_t++;
                       if (m_t == BURST) begin
                           m_mode = 2;
                           m_t    = 0;
                       end
                   end
                default: begin
                       m_t++;
                       if (m_t == D) begin
                           m_mode = 0;
                           m_t    = 0;
                       end
                   end
            endcase
        end
    end

    task automatic check1(input string req, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, name, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic e_sclk, e_en, e_sd, e_busy, e_rdy;
        int u, ph, k;
        e_sclk = 1'b0; e_en = 1'b1; e_sd = 1'b0; e_busy = 1'b0; e_rdy = 1'b1;
        if (!rst_n) begin
            check1("R8", "sclk",       sclk,       1'b0);
            check1("R8", "shift_en_n", shift_en_n, 1'b1);
            check1("R8", "sdata",      sdata,      1'b0);
            check1("R8", "busy",       busy,       1'b0);
            check1("R8", "in_ready",   in_ready,   1'b1);
        end else begin
            if (m_mode == 1) begin
                e_en = 1'b0; e_busy = 1'b1; e_rdy = 1'b0;
                if (m_t < L) begin
                    k = 0;
                end else begin
                    u  = m_t - L;
                    ph = u % (2 * H);
                    e_sclk = (ph < H);
                    k = u / (2 * H) + ((ph >= H) ? 1 : 0);
                end
                e_sd = (k < TOT) ? m_frame[k / 16][15 - (k % 16)] : 1'b0;
            end else if (m_mode == 2) begin
                e_busy = 1'b1; e_rdy = 1'b0;
            end
            check1("R1", "in_ready",   in_ready,   e_rdy);
            check1("R2/R3", "shift_en_n", shift_en_n, e_en);
            check1("R4", "sclk",       sclk,       e_sclk);
            check1("R5/R6", "sdata",   sdata,      e_sd);
            check1("R7", "busy",       busy,       e_busy);
        end
    end

    task automatic send_word(input logic [15:0] w, input int gap);
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_word  = w;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk); #2;
                break;
            end
        end
        in_valid = 1'b0;
        in_word  = 16'h0000;
        repeat (gap) @(posedge clk);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (2) @(posedge clk);
    endtask

    task automatic run();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // R5: two words back to back, distinct channel and code bytes
        send_word(16'h001F, 0);
        send_word(16'h024F, 0);
        // R1: offer a word while busy; it must not show up in the next burst
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_word  = 16'hDEAD;
        repeat (100) @(posedge clk);
        #2 in_valid = 1'b0;
        wait_idle();
        // R4/R5: extreme patterns with gaps between offers
        send_word(16'hFFFF, 3);
        send_word(16'h0000, 0);
        wait_idle();
        // R8: reset during collection discards the held word
        send_word(16'h0133, 1);
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        send_word(16'hA55A, 0);
        send_word(16'h5AA5, 0);
        // R8: reset in the middle of a burst
        repeat (40) @(posedge clk);
        #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        send_word(16'h0281, 2);
        send_word(16'h0007, 0);
        wait_idle();
        repeat (5) @(posedge clk);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule